// File: doc/BRIEF.md
# Alarm Real-Time Counter

A memory-mapped time base for a system bus. The bus clock samples a slow crystal clock (nominally 32768 Hz) through a bit synchronizer. A programmable prescaler turns the crystal's rising edges into ticks, and each tick advances a free-running 32-bit count. With the divider at its maximum of 1023, the count advances sixteen times per second. The low four bits then hold sixteenths of a second, and the whole-second value sits above them. The count wraps to zero after about eight years.

Two compare registers watch the count. When the count takes a value equal to either of them, a sticky flag is raised in a shared status word. Each tick also raises a sticky tick flag. Every flag has its own enable bit. A single interrupt line is asserted while any enabled flag is set. Software clears a flag by writing one to its bit.

The count only advances while the clock-select field holds the crystal code. A 32-bit scratch word lets software keep an overflow epoch next to the counter. All state lives in the bus-clock domain, so a read of the count is always a single coherent value.

Top module: `alarm_rtc`

## Requirements
- R1: After reset every register reads 0 and `irq` is low, except the divider, which reads 1023 (all ones in its 10-bit field).
- R2: Register offsets are: count 0x00, compare A 0x04, status 0x08, divider 0x0C (10 bits), compare B 0x18, clock select 0x1C (2 bits), scratch 0x40 (32 bits). Each register reads back what was last written, within its width. Any other offset, such as 0x14, reads 0 and ignores writes. A scratch write has no effect on the count.
- R3: While clock select equals 3, the count increments by one on every 2×(DIV+1)-th crystal rising edge. The edges are counted from the most recent write to the count or to the divider.
- R4: While clock select is any value other than 3, crystal edges do not advance the count.
- R5: A write to offset 0x00 loads the count. The count wraps from 0xFFFFFFFF to 0.
- R6: Status bit 0 (compare A event) or bit 4 (compare B event) is set when the count advances to, or is loaded with, a value equal to that compare register.
- R7: Status bit 1 (tick event) is set on every count advance.
- R8: In a status write, a 1 in bit 0, 1 or 4 clears that event flag, and a 0 leaves it unchanged.
- R9: Status bits 2 (compare A enable), 3 (tick enable) and 6 (compare B enable) are plain read/write. All other status bits read 0.
- R10: `irq` is high exactly when (bit0 and bit2) or (bit1 and bit3) or (bit4 and bit6).
- R11: Read data appears on `busRdata` one cycle after a read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| xtalClk | input | 1 | Slow crystal clock, sampled as data |
| busSel | input | 1 | Register access request |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 7 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
A prescaler that is out of step shows up as a count that is one tick early or late. This is visible on the first count read after a few crystal edges. A wrong compare or flag state appears on `irq` in the same cycle that the flag register changes. It is also visible on the next status read. The bench therefore drives crystal edges one at a time and keeps an edge-accurate model of the prescaler, so that a single missing or extra tick is caught by the next read.

// File: rtl/alarm_rtc_pkg.sv
package alarm_rtc_pkg;
  localparam int ADDR_W = 7;

  localparam logic [ADDR_W-1:0] OFF_COUNT   = 7'h00;
  localparam logic [ADDR_W-1:0] OFF_CMP_A   = 7'h04;
  localparam logic [ADDR_W-1:0] OFF_STATUS  = 7'h08;
  localparam logic [ADDR_W-1:0] OFF_DIV     = 7'h0C;
  localparam logic [ADDR_W-1:0] OFF_CMP_B   = 7'h18;
  localparam logic [ADDR_W-1:0] OFF_CLKSEL  = 7'h1C;
  localparam logic [ADDR_W-1:0] OFF_SCRATCH = 7'h40;

  localparam int BIT_EV_A    = 0;
  localparam int BIT_EV_TICK = 1;
  localparam int BIT_EN_A    = 2;
  localparam int BIT_EN_TICK = 3;
  localparam int BIT_EV_B    = 4;
  localparam int BIT_EN_B    = 6;

  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_XTAL = 2'd3;

  typedef struct packed {
    logic wrCount;
    logic wrCmpA;
    logic wrCmpB;
    logic wrStatus;
    logic wrDiv;
    logic wrClkSel;
    logic wrScratch;
    logic xtalEdge;
  } rtcStrobes_t;
endpackage

// File: rtl/alarm_rtc_ctrl.sv
module alarm_rtc_ctrl
  import alarm_rtc_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int DIV_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 xtalClk,
  input  logic                 busSel,
  input  logic                 busWr,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    countVal,
  input  logic [DATA_W-1:0]    cmpAVal,
  input  logic [DATA_W-1:0]    cmpBVal,
  input  logic [DATA_W-1:0]    statusWord,
  input  logic [DIV_W-1:0]     divVal,
  input  logic [SEL_W-1:0]     clkSelVal,
  input  logic [DATA_W-1:0]    scratchVal,
  output rtcStrobes_t          strobes,
  output logic [DATA_W-1:0]    busRdata
);
  logic [SYNC_STAGES-1:0] xtalSync;
  logic                   xtalPrev;
  logic                   wrReq;
  logic                   rdReq;
  logic [DATA_W-1:0]      rdMux;

  // crystal level is brought in through a plain bit synchronizer, then edge-detected
  always_ff @(posedge clk) begin
    if (!rstN) begin
      xtalSync <= '0;
      xtalPrev <= 1'b0;
    end else begin
      xtalSync <= {xtalSync[SYNC_STAGES-2:0], xtalClk};
      xtalPrev <= xtalSync[SYNC_STAGES-1];
    end
  end

  assign wrReq = busSel & busWr;
  assign rdReq = busSel & ~busWr;

  always_comb begin
    strobes.wrCount   = wrReq && (busAddr == OFF_COUNT);
    strobes.wrCmpA    = wrReq && (busAddr == OFF_CMP_A);
    strobes.wrCmpB    = wrReq && (busAddr == OFF_CMP_B);
    strobes.wrStatus  = wrReq && (busAddr == OFF_STATUS);
    strobes.wrDiv     = wrReq && (busAddr == OFF_DIV);
    strobes.wrClkSel  = wrReq && (busAddr == OFF_CLKSEL);
    strobes.wrScratch = wrReq && (busAddr == OFF_SCRATCH);
    strobes.xtalEdge  = xtalSync[SYNC_STAGES-1] & ~xtalPrev;
  end

  always_comb begin
    case (busAddr)
      OFF_COUNT:   rdMux = countVal;
      OFF_CMP_A:   rdMux = cmpAVal;
      OFF_STATUS:  rdMux = statusWord;
      OFF_DIV:     rdMux = {{(DATA_W-DIV_W){1'b0}}, divVal};
      OFF_CMP_B:   rdMux = cmpBVal;
      OFF_CLKSEL:  rdMux = {{(DATA_W-SEL_W){1'b0}}, clkSelVal};
      OFF_SCRATCH: rdMux = scratchVal;
      default:     rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)      busRdata <= '0;
    else if (rdReq) busRdata <= rdMux;
  end
endmodule

// File: rtl/alarm_rtc_datapath.sv
module alarm_rtc_datapath
  import alarm_rtc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 10,
  parameter int N_CMP  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  rtcStrobes_t       strobes,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] countVal,
  output logic [DATA_W-1:0] cmpAVal,
  output logic [DATA_W-1:0] cmpBVal,
  output logic [DATA_W-1:0] statusWord,
  output logic [DIV_W-1:0]  divVal,
  output logic [SEL_W-1:0]  clkSelVal,
  output logic [DATA_W-1:0] scratchVal,
  output logic              tickPulse,
  output logic              irq
);
  localparam int PRE_W = DIV_W + 1;

  logic [PRE_W-1:0]  preCnt;
  logic [PRE_W-1:0]  preMax;
  logic              preClear;
  logic              edgeLive;
  logic              countUpd;
  logic [DATA_W-1:0] nextCount;
  logic [DATA_W-1:0] cmpReg [N_CMP];
  logic [N_CMP-1:0]  cmpEv;
  logic [N_CMP-1:0]  cmpEn;
  logic              tickEv;
  logic              tickEn;

  assign preMax   = {divVal, 1'b1};
  assign preClear = strobes.wrCount | strobes.wrDiv;
  assign edgeLive = strobes.xtalEdge && (clkSelVal == SEL_XTAL) && !preClear;
  assign tickPulse = edgeLive && (preCnt == preMax);

  always_ff @(posedge clk) begin
    if (!rstN)            preCnt <= '0;
    else if (preClear)    preCnt <= '0;
    else if (tickPulse)   preCnt <= '0;
    else if (edgeLive)    preCnt <= preCnt + 1'b1;
  end

  assign countUpd  = strobes.wrCount | tickPulse;
  assign nextCount = strobes.wrCount ? wdata : countVal + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN)         countVal <= '0;
    else if (countUpd) countVal <= nextCount;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divVal     <= '1;
      clkSelVal  <= '0;
      scratchVal <= '0;
    end else begin
      if (strobes.wrDiv)     divVal     <= wdata[DIV_W-1:0];
      if (strobes.wrClkSel)  clkSelVal  <= wdata[SEL_W-1:0];
      if (strobes.wrScratch) scratchVal <= wdata;
    end
  end

  generate
    for (genvar gi = 0; gi < N_CMP; gi++) begin : g_cmp
      localparam int EV_BIT = (gi == 0) ? BIT_EV_A : BIT_EV_B;
      localparam int EN_BIT = (gi == 0) ? BIT_EN_A : BIT_EN_B;
      logic wrThis;
      logic hit;
      assign wrThis = (gi == 0) ? strobes.wrCmpA : strobes.wrCmpB;
      assign hit    = countUpd && (nextCount == cmpReg[gi]);

      always_ff @(posedge clk) begin
        if (!rstN) begin
          cmpReg[gi] <= '0;
          cmpEv[gi]  <= 1'b0;
          cmpEn[gi]  <= 1'b0;
        end else begin
          if (wrThis) cmpReg[gi] <= wdata;
          if (hit)
            cmpEv[gi] <= 1'b1;
          else if (strobes.wrStatus && wdata[EV_BIT])
            cmpEv[gi] <= 1'b0;
          if (strobes.wrStatus) cmpEn[gi] <= wdata[EN_BIT];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickEv <= 1'b0;
      tickEn <= 1'b0;
    end else begin
      if (tickPulse)
        tickEv <= 1'b1;
      else if (strobes.wrStatus && wdata[BIT_EV_TICK])
        tickEv <= 1'b0;
      if (strobes.wrStatus) tickEn <= wdata[BIT_EN_TICK];
    end
  end

  assign cmpAVal = cmpReg[0];
  assign cmpBVal = cmpReg[1];

  always_comb begin
    statusWord              = '0;
    statusWord[BIT_EV_A]    = cmpEv[0];
    statusWord[BIT_EV_TICK] = tickEv;
    statusWord[BIT_EN_A]    = cmpEn[0];
    statusWord[BIT_EN_TICK] = tickEn;
    statusWord[BIT_EV_B]    = cmpEv[1];
    statusWord[BIT_EN_B]    = cmpEn[1];
  end

  assign irq = |(cmpEv & cmpEn) | (tickEv & tickEn);
endmodule

// File: rtl/alarm_rtc.sv
module alarm_rtc
  import alarm_rtc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xtalClk,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [6:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);
  rtcStrobes_t       strobes;
  logic [DATA_W-1:0] countVal;
  logic [DATA_W-1:0] cmpAVal;
  logic [DATA_W-1:0] cmpBVal;
  logic [DATA_W-1:0] statusWord;
  logic [DIV_W-1:0]  divVal;
  logic [SEL_W-1:0]  clkSelVal;
  logic [DATA_W-1:0] scratchVal;
  logic              tickPulse;

  alarm_rtc_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W), .SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .xtalClk(xtalClk),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .countVal(countVal), .cmpAVal(cmpAVal), .cmpBVal(cmpBVal),
    .statusWord(statusWord), .divVal(divVal), .clkSelVal(clkSelVal),
    .scratchVal(scratchVal), .strobes(strobes), .busRdata(busRdata)
  );

  alarm_rtc_datapath #(.DATA_W(DATA_W), .DIV_W(DIV_W), .N_CMP(2)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wdata(busWdata),
    .countVal(countVal), .cmpAVal(cmpAVal), .cmpBVal(cmpBVal),
    .statusWord(statusWord), .divVal(divVal), .clkSelVal(clkSelVal),
    .scratchVal(scratchVal), .tickPulse(tickPulse), .irq(irq)
  );
endmodule

// File: rtl/alarm_rtc_checker.sv
module alarm_rtc_checker
  import alarm_rtc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input rtcStrobes_t       strobes,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] countVal,
  input logic [DATA_W-1:0] cmpAVal,
  input logic [DATA_W-1:0] statusWord,
  input logic [SEL_W-1:0]  clkSelVal,
  input logic              tickPulse,
  input logic              irq
);
  p_irq_needs_enable_r10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (statusWord[BIT_EN_A] | statusWord[BIT_EN_TICK] | statusWord[BIT_EN_B]));

  p_frozen_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    (clkSelVal != SEL_XTAL && !strobes.wrCount) |=> $stable(countVal));

  p_single_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrCount |=> (countVal == $past(countVal) || countVal == $past(countVal) + 1'b1));

  p_cmp_match_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusWord[BIT_EV_A]) |-> (countVal == $past(cmpAVal)));

  p_enables_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrStatus |=> $stable({statusWord[BIT_EN_B], statusWord[BIT_EN_TICK], statusWord[BIT_EN_A]}));

  p_tick_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrStatus && busWdata[BIT_EV_TICK] && !tickPulse) |=> !statusWord[BIT_EV_TICK]);

  p_tick_sets_r7: assert property (@(posedge clk) disable iff (!rstN)
    tickPulse |=> statusWord[BIT_EV_TICK]);
endmodule

bind alarm_rtc alarm_rtc_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .strobes(strobes), .busWdata(busWdata),
  .countVal(countVal), .cmpAVal(cmpAVal), .statusWord(statusWord),
  .clkSelVal(clkSelVal), .tickPulse(tickPulse), .irq(irq)
);

// File: tb/alarm_rtc_bench.sv
module alarm_rtc_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        xtalClk = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [6:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;

  int nTests = 0;
  int nFail = 0;
  bit finished = 0;

  // requirement-level model
  logic [31:0] mCount, mCmpA, mCmpB, mScr;
  logic        mEvA, mEvT, mEvB, mEnA, mEnT, mEnB;
  int          mDiv, mPre;
  logic [1:0]  mSel;

  alarm_rtc u_alarm_rtc (
    .clk(clk), .rstN(rstN), .xtalClk(xtalClk), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] expStatus();
    return {25'b0, mEnB, 1'b0, mEvB, mEnT, mEnA, mEvT, mEvA};
  endfunction

  function automatic logic expIrq();
    return (mEvA & mEnA) | (mEvT & mEnT) | (mEvB & mEnB);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busRead(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    @(negedge clk);
    busSel = 1'b0;
    d = busRdata;
  endtask

  task automatic modelLoadHit(input logic [31:0] v);
    if (v == mCmpA) mEvA = 1'b1;
    if (v == mCmpB) mEvB = 1'b1;
  endtask

  task automatic busWrite(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
    case (a)
      7'h00: begin mCount = d; mPre = 0; modelLoadHit(d); end
      7'h04: mCmpA = d;
      7'h18: mCmpB = d;
      7'h08: begin
        if (d[0]) mEvA = 1'b0;
        if (d[1]) mEvT = 1'b0;
        if (d[4]) mEvB = 1'b0;
        mEnA = d[2]; mEnT = d[3]; mEnB = d[6];
      end
      7'h0C: begin mDiv = int'(d[9:0]); mPre = 0; end
      7'h1C: mSel = d[1:0];
      7'h40: mScr = d;
      default: ;
    endcase
  endtask

  task automatic xtalPulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); xtalClk = 1'b1;
      repeat (4) @(negedge clk);
      xtalClk = 1'b0;
      repeat (4) @(negedge clk);
      if (mSel == 2'd3) begin
        if (mPre == 2 * mDiv + 1) begin
          mPre = 0;
          mCount = mCount + 1;
          mEvT = 1'b1;
          modelLoadHit(mCount);
        end else mPre++;
      end
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic checkState(input string req);
    logic [31:0] d;
    busRead(7'h00, d); chk({req, " count"}, d, mCount);
    busRead(7'h08, d); chk({req, " status"}, d, expStatus());
    chk({req, " irq"}, {31'b0, irq}, {31'b0, expIrq()});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    mCount = 0; mCmpA = 0; mCmpB = 0; mScr = 0;
    mEvA = 0; mEvT = 0; mEvB = 0; mEnA = 0; mEnT = 0; mEnB = 0;
    mDiv = 1023; mPre = 0; mSel = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    chk("R1 irq", {31'b0, irq}, 32'h0);
    busRead(7'h00, d); chk("R1 count", d, 32'h0);
    busRead(7'h04, d); chk("R1 cmpA", d, 32'h0);
    busRead(7'h18, d); chk("R1 cmpB", d, 32'h0);
    busRead(7'h08, d); chk("R1 status", d, 32'h0);
    busRead(7'h0C, d); chk("R1 divider", d, 32'd1023);
    busRead(7'h1C, d); chk("R1 clksel", d, 32'h0);
    busRead(7'h40, d); chk("R1 scratch", d, 32'h0);

    // R2 map and widths, R11 read hold
    busWrite(7'h40, 32'hA5C3_1E0F);
    busRead(7'h40, d); chk("R2 scratch", d, 32'hA5C3_1E0F);
    repeat (3) @(negedge clk);
    chk("R11 rdata held", busRdata, 32'hA5C3_1E0F);
    busWrite(7'h0C, 32'hFFFF_FC05);
    busRead(7'h0C, d); chk("R2 divider width", d, 32'h0000_0005);
    busWrite(7'h1C, 32'hFFFF_FFFE);
    busRead(7'h1C, d); chk("R2 clksel width", d, 32'h2);
    busWrite(7'h14, 32'hDEAD_BEEF);
    busRead(7'h14, d); chk("R2 unmapped", d, 32'h0);
    busWrite(7'h04, 32'h1234_5678);
    busRead(7'h04, d); chk("R2 cmpA", d, 32'h1234_5678);
    busWrite(7'h18, 32'h8765_4321);
    busRead(7'h18, d); chk("R2 cmpB", d, 32'h8765_4321);

    // R4 no counting with select != 3
    busWrite(7'h00, 32'h5);
    xtalPulses(20);
    checkState("R4 frozen");

    // R3 divider rate, R7 tick event
    busWrite(7'h0C, 32'h1);
    busWrite(7'h1C, 32'h3);
    xtalPulses(3);
    checkState("R3 before first tick");
    xtalPulses(1);
    checkState("R3 R7 first tick");
    xtalPulses(9);
    checkState("R3 further ticks");
    busWrite(7'h40, 32'h0);
    xtalPulses(2);
    checkState("R2 scratch no effect");

    // R5 wrap, R6 compare B at zero
    busWrite(7'h0C, 32'h0);
    busWrite(7'h18, 32'h0);
    busWrite(7'h00, 32'hFFFF_FFFE);
    xtalPulses(4);
    checkState("R5 R6 wrap");

    // R8 write-zero keeps, write-one clears, R9 enables, R10 irq
    busWrite(7'h08, 32'h0000_0044);
    checkState("R8 R10 zero keeps");
    busWrite(7'h08, 32'h0000_0017);
    checkState("R8 R9 clear");
    busWrite(7'h08, 32'hFFFF_FFA8);
    checkState("R9 enables only");

    // R6 compare A on load and on advance
    busWrite(7'h04, 32'h0000_0100);
    busWrite(7'h00, 32'h0000_0100);
    checkState("R6 load match");
    busWrite(7'h08, 32'h0000_0057);
    busWrite(7'h04, 32'h0000_0103);
    xtalPulses(4);
    checkState("R6 R10 advance match");

    // random mix
    for (int it = 0; it < 30; it++) begin
      int op;
      op = int'($urandom_range(0, 5));
      case (op)
        0: busWrite(7'h0C, $urandom_range(0, 3));
        1: busWrite(7'h1C, ($urandom_range(0, 3) == 0) ? 32'h1 : 32'h3);
        2: busWrite(7'h00, mCount + $urandom_range(0, 2));
        3: busWrite(7'h04, mCount + $urandom_range(1, 4));
        4: busWrite(7'h08, $urandom);
        default: busWrite(7'h18, mCount + $urandom_range(0, 3));
      endcase
      xtalPulses(int'($urandom_range(0, 10)));
      checkState("R3 R6 R7 R8 R10 random");
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule